// File: doc/BRIEF.md
# One-Bit Quadrature Downconverter Integrator

This block takes a one-bit comparator stream sampled at four times a 60 kHz carrier (240 kHz) and brings the carrier down to baseband without any multiplier. A two-bit phase slot counter steps through the four points of one carrier cycle, one step per accepted sample. The even slots feed the in-phase path and the odd slots feed the quadrature path. Each sample is first mapped to +1 or -1 and is then either added to or subtracted from its path accumulator. This is the same as mixing with a repeating 0/+1/0/-1 pattern on each path.

The two accumulators integrate over a window whose length in samples is set by an input. This long average acts as the low-pass filter: 12,000 samples gives 50 ms, and 6,000 samples gives 25 ms with finer timing and less processing gain. At the last sample of each window the block registers the signed in-phase and quadrature sums and an approximate magnitude |I|+|Q|, and pulses a done strobe. The accumulators then restart at zero for the next window, so no sample is lost at the boundary. The phase slot is not reset at the boundary, so the carrier phase reference runs on without a break.

Top module: `bitq_integrator`

## Requirements
- R1: A sample is taken on a clock edge where `smp_en` is high, and `smp_bit` high counts as +1 and low as -1. In slot 0 the value is added to the I sum and in slot 2 it is subtracted from it. In slot 1 it is added to the Q sum and in slot 3 it is subtracted from it. Slots run 0,1,2,3,0,... and the first sample after reset is in slot 0.
- R2: On cycles with `smp_en` low, the slot counter, window counter and accumulators keep their values, and `smp_bit` has no effect.
- R3: `win_done` is high for exactly the one cycle after the edge that takes the `win_len`-th sample of a window, and is low at every other time.
- R4: `i_sum`, `q_sum` and `mag` change only together with a `win_done` pulse, and hold their values between pulses.
- R5: The sample after a window's last sample is the first sample of the next window, and that window starts from zero sums. The slot sequence carries on across the boundary without restarting.
- R6: `mag` equals |`i_sum`| + |`q_sum`|.
- R7: A `win_len` of 0 or 1 makes every sample a window of its own.
- R8: Windows of 12,000 samples and of the largest value `win_len` can hold (16,383 by default) are summed without overflow, including the negative extreme of -8,192.
- R9: A synchronous active-high `rst` clears the slot counter, the window counter, the accumulators and all outputs, and takes effect even in the middle of a window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Qualifies one comparator sample at this edge |
| smp_bit | input | 1 | One-bit comparator sample |
| win_len | input | CNT_W (14) | Window length in samples (0 and 1 both mean 1) |
| i_sum | output | CNT_W+1 (15) | Signed in-phase sum of the last completed window |
| q_sum | output | CNT_W+1 (15) | Signed quadrature sum of the last completed window |
| mag | output | CNT_W+2 (16) | Approximate magnitude, sum of absolute values |
| win_done | output | 1 | One-cycle strobe marking new window results |

## Verification
The magnitude-bound property assumes that `win_len` stays constant for the whole of a window. The stimulus therefore changes `win_len` only while reset is held. The other properties assume nothing about the sample pattern or the spacing of `smp_en`. The stimulus includes idle gaps of varying length in which `smp_bit` toggles, back-to-back windows with no gap, a reset in the middle of a window, and both a zero and a full-scale window length, so that the properties are exercised at their edges.

// File: rtl/bitq_pkg.sv
package bitq_pkg;

    localparam int SLOT_W = 2;

    typedef enum logic {
        PATH_I = 1'b0,
        PATH_Q = 1'b1
    } path_e;

    // One mixed contribution: which path it goes to and whether it adds or subtracts.
    typedef struct packed {
        logic  valid;
        path_e path;
        logic  add;
    } mix_t;

    // Slot bit 0 picks the path. Slot bit 1 flips the sign of the +/-1 sample.
    function automatic mix_t mix_decode(input logic en, input logic bitv,
                                        input logic [SLOT_W-1:0] slot);
        mix_t m;
        m.valid = en;
        m.path  = path_e'(slot[0]);
        m.add   = bitv ^ slot[1];
        return m;
    endfunction

endpackage

// File: rtl/bitq_mixer.sv
module bitq_mixer
    import bitq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_en,
    input  logic              smp_bit,
    output mix_t              mix,
    output logic [SLOT_W-1:0] slot
);

    logic [SLOT_W-1:0] slot_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_r <= '0;
        end else if (smp_en) begin
            slot_r <= slot_r + SLOT_W'(1);
        end
    end

    always_comb begin
        mix  = mix_decode(smp_en, smp_bit, slot_r);
        slot = slot_r;
    end

endmodule

// File: rtl/bitq_window.sv
module bitq_window #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_en,
    input  logic [CNT_W-1:0] win_len,
    output logic             wrap
);

    logic [CNT_W-1:0] cnt_r;
    logic [CNT_W:0]   cnt_inc;
    logic             last;

    always_comb begin
        cnt_inc = {1'b0, cnt_r} + (CNT_W+1)'(1);
        last    = (cnt_inc >= {1'b0, win_len});
        wrap    = smp_en && last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_r <= '0;
        end else if (smp_en) begin
            cnt_r <= last ? '0 : cnt_inc[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/bitq_accum.sv
module bitq_accum
    import bitq_pkg::*;
#(
    parameter int    ACC_W = 15,
    parameter path_e PATH  = PATH_I
) (
    input  logic                    clk,
    input  logic                    rst,
    input  mix_t                    mix,
    input  logic                    wrap,
    output logic signed [ACC_W-1:0] acc_next
);

    logic signed [ACC_W-1:0] acc_r;

    always_comb begin
        acc_next = acc_r;
        if (mix.valid && (mix.path == PATH)) begin
            acc_next = mix.add ? acc_r + ACC_W'(1) : acc_r - ACC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || wrap) begin
            acc_r <= '0;
        end else begin
            acc_r <= acc_next;
        end
    end

endmodule

// File: rtl/bitq_integrator.sv
module bitq_integrator
    import bitq_pkg::*;
#(
    parameter  int CNT_W = 14,
    localparam int ACC_W = CNT_W + 1,
    localparam int MAG_W = ACC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_en,
    input  logic                    smp_bit,
    input  logic [CNT_W-1:0]        win_len,
    output logic signed [ACC_W-1:0] i_sum,
    output logic signed [ACC_W-1:0] q_sum,
    output logic [MAG_W-1:0]        mag,
    output logic                    win_done
);

    localparam int NPATH = 2;

    mix_t              mix;
    logic [SLOT_W-1:0] slot_q;
    logic              wrap;
    logic signed [ACC_W-1:0] path_nx [NPATH];
    logic [MAG_W-1:0]  mag_nx;

    function automatic logic [ACC_W-1:0] mag_of(input logic signed [ACC_W-1:0] v);
        return v[ACC_W-1] ? ACC_W'(-v) : ACC_W'(v);
    endfunction

    bitq_mixer u_mix (
        .clk     (clk),
        .rst     (rst),
        .smp_en  (smp_en),
        .smp_bit (smp_bit),
        .mix     (mix),
        .slot    (slot_q)
    );

    bitq_window #(.CNT_W(CNT_W)) u_win (
        .clk     (clk),
        .rst     (rst),
        .smp_en  (smp_en),
        .win_len (win_len),
        .wrap    (wrap)
    );

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        bitq_accum #(.ACC_W(ACC_W), .PATH(path_e'(g))) u_acc (
            .clk      (clk),
            .rst      (rst),
            .mix      (mix),
            .wrap     (wrap),
            .acc_next (path_nx[g])
        );
    end

    always_comb begin
        mag_nx = MAG_W'(mag_of(path_nx[PATH_I])) + MAG_W'(mag_of(path_nx[PATH_Q]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            i_sum    <= '0;
            q_sum    <= '0;
            mag      <= '0;
            win_done <= 1'b0;
        end else begin
            win_done <= wrap;
            if (wrap) begin
                i_sum <= path_nx[PATH_I];
                q_sum <= path_nx[PATH_Q];
                mag   <= mag_nx;
            end
        end
    end

endmodule

// File: rtl/bitq_checker.sv
module bitq_checker #(
    parameter  int CNT_W = 14,
    localparam int ACC_W = CNT_W + 1,
    localparam int MAG_W = ACC_W + 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    smp_en,
    input logic [CNT_W-1:0]        win_len,
    input logic signed [ACC_W-1:0] i_sum,
    input logic signed [ACC_W-1:0] q_sum,
    input logic [MAG_W-1:0]        mag,
    input logic                    win_done,
    input logic [1:0]              slot_q
);

    function automatic int absv(input logic signed [ACC_W-1:0] v);
        int t;
        t = int'(v);
        return (t < 0) ? -t : t;
    endfunction

    // R3
    done_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
        win_done |-> $past(smp_en));

    // R2
    slot_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> $stable(slot_q));

    // R4
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !win_done |-> ($stable(i_sum) && $stable(q_sum) && $stable(mag)));

    // R6
    mag_sum_chk: assert property (@(posedge clk) disable iff (rst)
        int'(mag) == absv(i_sum) + absv(q_sum));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        win_done |-> (int'(mag) <= ((win_len == '0) ? 1 : int'(win_len))));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (i_sum == '0 && q_sum == '0 && mag == '0 && !win_done && slot_q == 2'd0));

endmodule

bind bitq_integrator bitq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_en   (smp_en),
    .win_len  (win_len),
    .i_sum    (i_sum),
    .q_sum    (q_sum),
    .mag      (mag),
    .win_done (win_done),
    .slot_q   (slot_q)
);

// File: tb/sim_bitq_integrator.sv
module sim_bitq_integrator;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_en = 1'b0;
    logic               smp_bit = 1'b0;
    logic [13:0]        win_len = 14'd8;
    logic signed [14:0] i_sum;
    logic signed [14:0] q_sum;
    logic [15:0]        mag;
    logic               win_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bitq_integrator u0 (
        .clk      (clk),
        .rst      (rst),
        .smp_en   (smp_en),
        .smp_bit  (smp_bit),
        .win_len  (win_len),
        .i_sum    (i_sum),
        .q_sum    (q_sum),
        .mag      (mag),
        .win_done (win_done)
    );

    // Vectors: window length, pattern kind, expected I, Q, magnitude (R1, R6, R7, R8)
    localparam int NVEC = 9;
    localparam int V_LEN  [NVEC] = '{8, 8, 8, 8, 5, 6, 1, 12000, 16383};
    localparam int V_KIND [NVEC] = '{0, 1, 2, 3, 1, 2, 0, 1, 3};
    localparam int V_I    [NVEC] = '{0, 4, 4, -4, 3, 3, 1, 6000, -8192};
    localparam int V_Q    [NVEC] = '{0, 4, -4, -4, 2, -3, 0, 6000, -8191};
    localparam int V_M    [NVEC] = '{0, 8, 8, 8, 5, 6, 1, 12000, 16383};

    function automatic logic gen_bit(input int kind, input int k);
        case (kind)
            0:       return 1'b1;
            1:       return (k % 4) < 2;
            2:       return ((k + 1) % 4) < 2;
            default: return (k % 4) >= 2;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input logic b, input bit last, input string req);
        @(negedge clk);
        smp_en = 1'b1;
        smp_bit = b;
        @(negedge clk);
        smp_en = 1'b0;
        check(req, int'(win_done), int'(last));
    endtask

    task automatic run_win(input int len, input int kind, inout int k, input string req);
        int n;
        n = (len < 1) ? 1 : len;
        for (int s = 0; s < n; s++) begin
            send(gen_bit(kind, k), s == n - 1, req);
            k++;
        end
    endtask

    task automatic check_res(input string req, input int ei, input int eq, input int em);
        check({req, " i_sum"}, int'(i_sum), ei);
        check({req, " q_sum"}, int'(q_sum), eq);
        check({req, " mag"}, int'(mag), em);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int k;
        int hold_i;
        // R9 reset state
        win_len = 14'd8;
        do_reset();
        check_res("R9 reset", 0, 0, 0);
        check("R9 reset done", int'(win_done), 0);

        // Vector table: R1, R6, R7, R8
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            rst = 1'b1;
            win_len = 14'(V_LEN[v]);
            do_reset();
            k = 0;
            run_win(V_LEN[v], V_KIND[v], k, "R3 done at window end");
            check_res($sformatf("R1/R6/R8 vec%0d", v), V_I[v], V_Q[v], V_M[v]);
        end

        // R5: back-to-back windows of 3, slot runs on across boundaries
        @(negedge clk);
        rst = 1'b1;
        win_len = 14'd3;
        do_reset();
        k = 0;
        run_win(3, 1, k, "R5 done");
        check_res("R5 win1", 2, 1, 3);
        run_win(3, 1, k, "R5 done");
        check_res("R5 win2", 1, 2, 3);
        run_win(3, 1, k, "R5 done");
        check_res("R5 win3", 2, 1, 3);

        // R2/R4: idle cycles with toggling bit change nothing
        hold_i = int'(i_sum);
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            smp_bit = ~smp_bit;
            check("R4 no done while idle", int'(win_done), 0);
        end
        check("R4 i_sum held", int'(i_sum), hold_i);
        run_win(3, 1, k, "R2 done");
        check_res("R2 slot held over idle", 1, 2, 3);

        // R7: zero length, each sample its own window
        @(negedge clk);
        rst = 1'b1;
        win_len = 14'd0;
        do_reset();
        send(1'b0, 1'b1, "R7 done slot0");
        check_res("R7 first", -1, 0, 1);
        send(1'b1, 1'b1, "R7 done slot1");
        check_res("R7 second", 0, 1, 1);

        // R9: reset mid-window restarts slot and count
        @(negedge clk);
        rst = 1'b1;
        win_len = 14'd4;
        do_reset();
        k = 0;
        send(1'b1, 1'b0, "R9 pre");
        send(1'b1, 1'b0, "R9 pre");
        do_reset();
        check_res("R9 mid reset clear", 0, 0, 0);
        k = 0;
        run_win(4, 1, k, "R9 done");
        check_res("R9 after reset", 2, 2, 4);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule